// File: doc/BRIEF.md
# Programmable Eight-Input Interrupt Controller

This block collects up to eight interrupt requests from peripherals and presents a single interrupt line to a processor. A rising edge on a request input latches a pending bit. Pending bits that are not masked compete by fixed priority, with input 0 the most urgent. The controller raises its interrupt output only when the winner outranks every request already being serviced. This allows a higher-priority device to interrupt the handler of a lower one, while equal or lower requests wait.

Software reaches the block through a two-address port bus. The command port is address 0 and the data port is address 1. A command byte with bit 4 set starts initialization, and the following data-port write supplies the vector base. The processor claims an interrupt with an acknowledge cycle, which the block decodes from the control-bus qualifiers. In that cycle the block drives the vector base plus the winning input index onto the data bus and moves that request from pending to in-service. The handler finishes by writing the end-of-interrupt code 0x20 to the command port.

Top module: `prog_intc`

## Requirements
- R1: After reset the mask register reads 0xFF, the vector base is 0x00, no request is pending or in service, and `intr_o` is low.
- R2: A rising edge on `irq_in[n]` sets pending bit n on the next clock. The bit is cleared when request n is acknowledged. An input held high after its acknowledge does not set the bit again.
- R3: Mask bit n = 1 stops pending request n from raising `intr_o`. A data-port write (address 1) outside initialization loads the mask. A read of address 1 returns the mask, and a read of address 0 returns the pending register.
- R4: Among pending unmasked requests, the lowest index wins.
- R5: An acknowledge cycle is `cyc_valid` high with `cyc_is_mem`, `cyc_is_write` and `cyc_is_data` all low. In it, `data_out` carries base + winning index with `data_oe` high, and at the clock edge the winner's in-service bit is set and its pending bit is cleared. Any other qualifier combination has no effect.
- R6: `intr_o` is high only if the winning pending request has strictly higher priority (a lower index) than every in-service request.
- R7: Writing 0x20 to address 0 clears the highest-priority in-service bit. If nothing is in service, the write does nothing.
- R8: A write to address 0 with bit 4 set clears all pending and in-service bits and arms initialization. The next write to address 1 loads the vector base from bits 7..3 and ignores bits 2..0. That write leaves the mask unchanged.
- R9: An acknowledge cycle while `intr_o` is low returns base + 7 and changes no state.
- R10: `data_oe` is high only during a read or an acknowledge cycle, and `data_out` is 0 otherwise. Acknowledge takes precedence over a read in the same cycle.
- R11: A command-port write with bit 4 clear whose value is not 0x20 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Edge-sensitive request inputs, index 0 most urgent |
| bus_addr | input | 1 | Port select: 0 command, 1 data/mask |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| cyc_valid | input | 1 | Control-bus cycle qualifier valid |
| cyc_is_mem | input | 1 | Memory (1) or I/O (0) cycle |
| cyc_is_write | input | 1 | Write (1) or read (0) cycle |
| cyc_is_data | input | 1 | Data (1) or control (0) cycle |
| data_out | output | 8 | Read data or acknowledge vector |
| data_oe | output | 1 | Data bus drive enable |
| intr_o | output | 1 | Interrupt request to the processor |

## Verification
The checker watches four properties on every cycle:
- `intr_o` is never raised without an unmasked pending bit.
- A pending winner that drives `intr_o` always outranks the highest in-service bit.
- A granted acknowledge adds exactly one in-service bit, and an end-of-interrupt removes exactly one.
- A spurious acknowledge leaves the in-service state untouched, and the data bus is zero whenever it is not driven.

Some behaviours only the bench scenarios can show. These are the exact vector values produced by base programming with ignored low bits, and the absence of re-triggering on held inputs. They also include the nesting order across several handlers, the flush on re-initialization, and that unknown commands and non-acknowledge qualifier combinations are ignored. A random phase compares every output against a behavioural model on every clock.

// File: rtl/intc_pkg.sv
package intc_pkg;
   typedef enum logic {
      PORT_CMD  = 1'b0,
      PORT_DATA = 1'b1
   } intc_port_e;
endpackage

// File: rtl/intc_req_latch.sv
module intc_req_latch #(
   parameter int N_IRQ = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] irq_in,
   input  logic [N_IRQ-1:0] clr_onehot,
   input  logic             flush,
   output logic [N_IRQ-1:0] irr_q
);
   logic [N_IRQ-1:0] irq_d;

   for (genvar g = 0; g < N_IRQ; g++) begin : g_line
      logic rise;
      assign rise = irq_in[g] & ~irq_d[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_d[g] <= 1'b0;
            irr_q[g] <= 1'b0;
         end else begin
            irq_d[g] <= irq_in[g];
            if (flush)
               irr_q[g] <= 1'b0;
            else
               irr_q[g] <= (irr_q[g] & ~clr_onehot[g]) | rise;
         end
      end
   end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
   parameter int N_IRQ     = 8,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IDX_W    = $clog2(N_IRQ)
) (
   input  logic [N_IRQ-1:0] req,
   output logic             any,
   output logic [IDX_W-1:0] idx,
   output logic [N_IRQ-1:0] onehot
);
   assign any = |req;

   if (LOW_FIRST) begin : g_low
      always_comb begin
         idx = '0;
         for (int i = N_IRQ - 1; i >= 0; i--)
            if (req[i]) idx = IDX_W'(i);
      end
   end else begin : g_high
      always_comb begin
         idx = '0;
         for (int i = 0; i < N_IRQ; i++)
            if (req[i]) idx = IDX_W'(i);
      end
   end

   assign onehot = any ? (N_IRQ'(1) << idx) : '0;
endmodule

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs #(
   parameter int N_IRQ     = 8,
   parameter int DATA_W    = 8,
   parameter int INIT_BIT  = 4,
   localparam int IDX_W    = $clog2(N_IRQ),
   localparam int BASE_W   = DATA_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_hit,
   input  logic              wr_data,
   input  logic [DATA_W-1:0] wdata,
   output logic [N_IRQ-1:0]  mask_q,
   output logic [BASE_W-1:0] base_q
);
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '1;
         base_q  <= '0;
         armed_q <= 1'b0;
      end else begin
         if (init_hit)
            armed_q <= 1'b1;
         else if (wr_data) begin
            if (armed_q) begin
               base_q  <= wdata[DATA_W-1:IDX_W];
               armed_q <= 1'b0;
            end else begin
               mask_q <= wdata[N_IRQ-1:0];
            end
         end
      end
   end
endmodule

// File: rtl/prog_intc.sv
module prog_intc #(
   parameter int          N_IRQ     = 8,
   parameter int          DATA_W    = 8,
   parameter int          INIT_BIT  = 4,
   parameter logic [7:0]  EOI_CODE  = 8'h20,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IRQ-1:0]  irq_in,
   input  logic              bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              cyc_valid,
   input  logic              cyc_is_mem,
   input  logic              cyc_is_write,
   input  logic              cyc_is_data,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              intr_o
);
   import intc_pkg::*;

   localparam int IDX_W  = $clog2(N_IRQ);
   localparam int BASE_W = DATA_W - IDX_W;

   initial begin
      assert (N_IRQ == (1 << IDX_W)) else $error("N_IRQ must be a power of two");
      assert (N_IRQ <= DATA_W) else $error("mask must fit the data bus");
      assert (INIT_BIT < DATA_W) else $error("INIT_BIT outside data bus");
      assert (EOI_CODE[INIT_BIT] == 1'b0) else $error("EOI code collides with init");
   end

   logic              wr_cmd, wr_data, init_hit, eoi_hit, ack_hit, grant;
   logic [N_IRQ-1:0]  irr_q, isr_q, mask_q, pend;
   logic [BASE_W-1:0] base_q;
   logic              pend_any, isr_any;
   logic [IDX_W-1:0]  pend_idx, isr_idx, vec_idx;
   logic [N_IRQ-1:0]  pend_oh, isr_oh, irr_clr;
   logic [DATA_W-1:0] vector, read_val;

   assign wr_cmd   = bus_wr && (bus_addr == PORT_CMD);
   assign wr_data  = bus_wr && (bus_addr == PORT_DATA);
   assign init_hit = wr_cmd && bus_wdata[INIT_BIT];
   assign eoi_hit  = wr_cmd && (bus_wdata == DATA_W'(EOI_CODE));
   assign ack_hit  = cyc_valid && !cyc_is_mem && !cyc_is_write && !cyc_is_data;

   intc_cfg_regs #(
      .N_IRQ(N_IRQ), .DATA_W(DATA_W), .INIT_BIT(INIT_BIT)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n), .init_hit(init_hit), .wr_data(wr_data),
      .wdata(bus_wdata), .mask_q(mask_q), .base_q(base_q)
   );

   assign irr_clr = grant ? pend_oh : '0;

   intc_req_latch #(.N_IRQ(N_IRQ)) req_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_onehot(irr_clr),
      .flush(init_hit), .irr_q(irr_q)
   );

   assign pend = irr_q & ~mask_q;

   intc_prio_pick #(.N_IRQ(N_IRQ), .LOW_FIRST(LOW_FIRST)) pick_pend_i (
      .req(pend), .any(pend_any), .idx(pend_idx), .onehot(pend_oh)
   );

   intc_prio_pick #(.N_IRQ(N_IRQ), .LOW_FIRST(LOW_FIRST)) pick_isr_i (
      .req(isr_q), .any(isr_any), .idx(isr_idx), .onehot(isr_oh)
   );

   if (LOW_FIRST) begin : g_cmp_low
      assign intr_o = pend_any && (!isr_any || (pend_idx < isr_idx));
   end else begin : g_cmp_high
      assign intr_o = pend_any && (!isr_any || (pend_idx > isr_idx));
   end

   assign grant = ack_hit && intr_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         isr_q <= '0;
      else if (init_hit)
         isr_q <= '0;
      else
         isr_q <= (isr_q & ~(eoi_hit ? isr_oh : '0)) | (grant ? pend_oh : '0);
   end

   assign vec_idx  = intr_o ? pend_idx : '1;
   assign vector   = {base_q, vec_idx};
   assign read_val = (bus_addr == PORT_DATA) ? DATA_W'(mask_q) : DATA_W'(irr_q);
   assign data_oe  = ack_hit || bus_rd;

   always_comb begin
      if (ack_hit)     data_out = vector;
      else if (bus_rd) data_out = read_val;
      else             data_out = '0;
   end
endmodule

// File: rtl/prog_intc_chk.sv
module prog_intc_chk #(
   parameter int N_IRQ  = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              intr_o,
   input logic              ack_hit,
   input logic              eoi_hit,
   input logic              bus_wr,
   input logic              data_oe,
   input logic [DATA_W-1:0] data_out,
   input logic [N_IRQ-1:0]  irr_q,
   input logic [N_IRQ-1:0]  isr_q,
   input logic [N_IRQ-1:0]  mask_q
);
   logic [N_IRQ-1:0] pend_c, pend_low, isr_low;
   assign pend_c   = irr_q & ~mask_q;
   assign pend_low = pend_c & (~pend_c + 1'b1);
   assign isr_low  = isr_q & (~isr_q + 1'b1);

   a_r3_intr_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      intr_o |-> (pend_c != '0));

   a_r6_outranks_service: assert property (@(posedge clk) disable iff (!rst_n)
      (intr_o && (isr_q != '0)) |-> (pend_low < isr_low));

   a_r5_grant_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && intr_o && !bus_wr) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

   a_r7_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_hit && !ack_hit && (isr_q != '0)) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));

   a_r9_spurious_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !intr_o && !bus_wr) |=> $stable(isr_q));

   a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !data_oe |-> (data_out == '0));
endmodule

bind prog_intc prog_intc_chk #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .intr_o(intr_o), .ack_hit(ack_hit),
   .eoi_hit(eoi_hit), .bus_wr(bus_wr), .data_oe(data_oe), .data_out(data_out),
   .irr_q(irr_q), .isr_q(isr_q), .mask_q(mask_q)
);

// File: tb/prog_intc_tb.sv
module prog_intc_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_in = '0;
   logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       cyc_valid = 1'b0, cyc_is_mem = 1'b1, cyc_is_write = 1'b1, cyc_is_data = 1'b1;
   logic [7:0] data_out;
   logic       data_oe, intr_o;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   bit [7:0] m_irr, m_isr, m_mask, m_base, m_prev;
   bit       m_wait;

   always #10 clk = ~clk;

   prog_intc dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .cyc_valid(cyc_valid), .cyc_is_mem(cyc_is_mem), .cyc_is_write(cyc_is_write),
      .cyc_is_data(cyc_is_data), .data_out(data_out), .data_oe(data_oe), .intr_o(intr_o)
   );

   function automatic int first_set(input bit [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return i;
      return 8;
   endfunction

   function automatic bit m_intr();
      int p, s;
      p = first_set(m_irr & ~m_mask);
      s = first_set(m_isr);
      return (p < 8) && (p < s);
   endfunction

   function automatic bit is_ack();
      return cyc_valid && !cyc_is_mem && !cyc_is_write && !cyc_is_data;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_irr = 0; m_isr = 0; m_mask = 8'hFF; m_base = 0; m_prev = 0; m_wait = 0;
   endtask

   task automatic model_step();
      bit [7:0] rise;
      bit gi;
      int p, s;
      gi = m_intr();
      p = first_set(m_irr & ~m_mask);
      s = first_set(m_isr);
      rise = irq_in & ~m_prev;
      m_prev = irq_in;
      if (is_ack() && gi) begin m_irr[p] = 1'b0; m_isr[p] = 1'b1; end
      if (bus_wr && !bus_addr && bus_wdata == 8'h20 && s < 8) m_isr[s] = 1'b0;
      m_irr |= rise;
      if (bus_wr && !bus_addr && bus_wdata[4]) begin m_irr = 0; m_isr = 0; m_wait = 1; end
      if (bus_wr && bus_addr) begin
         if (m_wait) begin m_base = bus_wdata & 8'hF8; m_wait = 0; end
         else m_mask = bus_wdata;
      end
   endtask

   task automatic idle_in();
      bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
      cyc_valid = 0; cyc_is_mem = 1; cyc_is_write = 1; cyc_is_data = 1;
   endtask

   task automatic tick(input string tag, input int ed = -1, input int ei = -1);
      int edat;
      #5;
      if (is_ack()) edat = m_intr() ? m_base + first_set(m_irr & ~m_mask) : m_base + 7;
      else if (bus_rd) edat = bus_addr ? m_mask : m_irr;
      else edat = 0;
      chk({tag, " model"}, {intr_o, data_oe, data_out},
          {m_intr(), is_ack() || bus_rd, edat[7:0]});
      if (ed >= 0) chk({tag, " data"}, data_out, ed);
      if (ei >= 0) chk({tag, " intr"}, intr_o, ei);
      @(posedge clk);
      model_step();
      @(negedge clk);
      idle_in();
   endtask

   task automatic wr(input bit a, input bit [7:0] d, input string tag);
      bus_wr = 1; bus_addr = a; bus_wdata = d; tick(tag);
   endtask

   task automatic rd(input bit a, input string tag, input int exp);
      bus_rd = 1; bus_addr = a; tick(tag, exp);
   endtask

   task automatic ackc(input string tag, input int exp);
      cyc_valid = 1; cyc_is_mem = 0; cyc_is_write = 0; cyc_is_data = 0; tick(tag, exp);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      idle_in();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd(1, "R1", 8'hFF);
      rd(0, "R1", 0);
      tick("R1", -1, 0);
      ackc("R1", 8'h07);
      // R8 init, low base bits dropped, mask untouched
      wr(0, 8'h10, "R8");
      wr(1, 8'h27, "R8");
      rd(1, "R8", 8'hFF);
      // R2 edge latch, R3 masked
      irq_in[3] = 1; tick("R2", -1, 0);
      rd(0, "R3", 8'h08);
      tick("R3", -1, 0);
      wr(1, 8'h00, "R3");
      tick("R3", -1, 1);
      ackc("R5", 8'h23);
      irq_in[3] = 0;
      wr(0, 8'h20, "R7");
      tick("R7", -1, 0);
      // R4 priority, R6 nesting
      irq_in[5] = 1; irq_in[2] = 1; tick("R4");
      tick("R4", -1, 1);
      ackc("R4", 8'h22);
      tick("R6", -1, 0);
      irq_in[1] = 1; tick("R6");
      tick("R6", -1, 1);
      ackc("R6", 8'h21);
      wr(0, 8'h20, "R7");
      tick("R7", -1, 0);
      wr(0, 8'h20, "R7");
      tick("R7", -1, 1);
      ackc("R5", 8'h25);
      rd(0, "R2", 8'h00);
      wr(0, 8'h20, "R7");
      wr(0, 8'h20, "R7");
      tick("R7", -1, 0);
      // R5 non-acknowledge qualifiers, R10 bus quiet
      irq_in = 0; tick("R5");
      irq_in[0] = 1; tick("R5");
      tick("R5", -1, 1);
      cyc_valid = 1; cyc_is_mem = 1; cyc_is_write = 0; cyc_is_data = 0; tick("R10", 0);
      cyc_valid = 1; cyc_is_mem = 0; cyc_is_write = 0; cyc_is_data = 1; tick("R5", 0);
      tick("R5", -1, 1);
      bus_rd = 1; bus_addr = 1; ackc("R10", 8'h20);
      wr(0, 8'h20, "R7");
      // R9 spurious acknowledge
      tick("R9", -1, 0);
      ackc("R9", 8'h27);
      rd(0, "R9", 0);
      // R11 unknown commands ignored
      wr(0, 8'h00, "R11");
      wr(0, 8'h07, "R11");
      rd(1, "R11", 8'h00);
      // R8 re-init flushes pending
      irq_in = 0; tick("R8");
      irq_in[6] = 1; tick("R8");
      wr(0, 8'h13, "R8");
      rd(0, "R8", 0);
      tick("R8", -1, 0);
      wr(1, 8'h55, "R8");
      // R3 mask 0x7E leaves only inputs 0 and 7
      wr(1, 8'h7E, "R3");
      irq_in = 0; tick("R3");
      irq_in[4] = 1; irq_in[7] = 1; tick("R3");
      tick("R3", -1, 1);
      ackc("R3", 8'h57);
      rd(0, "R3", 8'h10);
      wr(0, 8'h20, "R7");
      // random phase against the model
      for (int k = 0; k < 600; k++) begin
         int op;
         irq_in = irq_in ^ 8'($urandom & $urandom);
         op = $urandom % 12;
         case (op)
            0, 1: begin cyc_valid = 1; cyc_is_mem = 0; cyc_is_write = 0; cyc_is_data = 0; end
            2: begin cyc_valid = 1; {cyc_is_mem, cyc_is_write, cyc_is_data} = 3'($urandom); end
            3: begin bus_rd = 1; bus_addr = 1'($urandom); end
            4: begin bus_wr = 1; bus_addr = 1; bus_wdata = 8'($urandom); end
            5, 6: begin bus_wr = 1; bus_addr = 0; bus_wdata = 8'h20; end
            7: if ($urandom % 8 == 0) begin bus_wr = 1; bus_addr = 0; bus_wdata = 8'h10; end
            8: begin bus_wr = 1; bus_addr = 0; bus_wdata = 8'($urandom) & 8'hEF; end
            default: ;
         endcase
         tick("R4 R6 random");
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule